// File: doc/BRIEF.md
# Tick-Driven Watchdog Timer with Reset Pulse

This block is a watchdog timer that software programs through a small register port. It counts down in coarse time units. Software writes an 8-bit count. The count drops by one on each selected tick. If the count reaches zero before software writes it again, the block raises a sticky expiry flag and drives a fixed-length active-low pulse. That pulse can also be steered onto a keyboard-reset line.

Writing the count register both arms the timer and refreshes it, so a periodic write acts as the keepalive. Writing zero stops the timer. Reading the count register returns the time left. External tick inputs supply the time base: one pulse per second and one pulse per minute, and a control bit picks which one is used. Keyboard and mouse event pulses can be allowed to refresh a running count with the value last written. The register port is plain: a write takes effect at the clock edge, a read is combinational from the address, and the port has no back-pressure. Ticks and events are single-cycle pulses.

Top module: `tick_watchdog`

## Requirements
- R1: After reset every register reads 0, the count is 0 and both `wdt_out_n` and `kbrst_n` are high.
- R2: A write to address 2 loads the written value into both the count and the reload value at that clock edge, and a read of address 2 returns the live count. A count of 0 is stopped and never changes on ticks or events.
- R3: While the count is nonzero, each cycle with the selected tick high lowers it by one. Control bit 3 at address 1 selects the tick: 0 selects `sec_tick` and 1 selects `min_tick`. The tick that is not selected has no effect.
- R4: A decrement from 1 to 0 sets status bit 4 at address 3. The count then stays at 0 until it is written.
- R5: When the activate bit (bit 0 at address 0) is 1, `wdt_out_n` is low for exactly 16 cycles, starting with the cycle after the expiring edge. When the activate bit is 0, `wdt_out_n` stays high.
- R6: `kbrst_n` follows the `wdt_out_n` pulse only when control bit 1 is 1. Otherwise it stays high.
- R7: While the count is nonzero, a `kbd_evt` pulse reloads the reload value when control bit 2 or status bit 7 is 1, and a `mouse_evt` pulse reloads it when status bit 6 is 1. Events have no effect when they are disabled or when the count is 0.
- R8: Writing 0 to status bit 4 clears it, and writing 1 leaves it unchanged. If an expiry occurs in the same cycle as a clearing write, the flag is set. Status bits 7 and 6 take the written value.
- R9: Within one cycle, a write to the count register takes priority over an event reload, and an event reload takes priority over a tick. Reserved bits read as 0: address 0 uses only bit 0, address 1 uses only bits 3:1, and address 3 uses only bits 7, 6 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address (0 activate, 1 control, 2 count, 3 status) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| min_tick | input | 1 | One-cycle pulse, once per minute |
| kbd_evt | input | 1 | One-cycle keyboard activity pulse |
| mouse_evt | input | 1 | One-cycle mouse activity pulse |
| wdt_out_n | output | 1 | Active-low expiry pulse |
| kbrst_n | output | 1 | Active-low keyboard-reset pulse |

## Verification
The hardest situations to create from the ports are collisions within a single cycle. These are an expiring tick that lands together with a flag-clearing write, a re-expiry while a pulse is still running, and an event, a tick and a count write arriving in the same cycle. Directed sequences set each of these up with small counts so that the collision cycle is known in advance. Several thousand random cycles then follow. In them, count writes use values of 0 to 5 and ticks and events occur often, so expiries arrive frequently and overlap with random register writes. A cycle-level model in the bench predicts every read value and both output pins on every cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    SEL_ACT  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  localparam int CTRL_MINUTE_BIT = 3;
  localparam int CTRL_KBD_BIT    = 2;
  localparam int CTRL_ROUTE_BIT  = 1;
  localparam int STAT_KBD_BIT    = 7;
  localparam int STAT_MOUSE_BIT  = 6;
  localparam int STAT_FLAG_BIT   = 4;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] count,
  input  logic          expire,
  output logic [DW-1:0] rdata,
  output logic          act,
  output logic          minute_unit,
  output logic          kbd_en,
  output logic          mouse_en,
  output logic          route_kbrst,
  output logic          cnt_load
);
  logic       act_q;
  logic [2:0] ctrl_q;
  logic       st_kbd_q, st_mouse_q, flag_q;
  reg_sel_e   sel;
  logic       unused_wbits;

  assign sel          = reg_sel_e'(addr);
  assign unused_wbits = wdata[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q      <= 1'b0;
      ctrl_q     <= '0;
      st_kbd_q   <= 1'b0;
      st_mouse_q <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      if (wr && sel == SEL_ACT)  act_q  <= wdata[0];
      if (wr && sel == SEL_CTRL) ctrl_q <= wdata[CTRL_MINUTE_BIT:CTRL_ROUTE_BIT];
      if (wr && sel == SEL_STAT) begin
        st_kbd_q   <= wdata[STAT_KBD_BIT];
        st_mouse_q <= wdata[STAT_MOUSE_BIT];
      end
      if (expire)
        flag_q <= 1'b1;
      else if (wr && sel == SEL_STAT && !wdata[STAT_FLAG_BIT])
        flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_ACT:  rdata[0] = act_q;
      SEL_CTRL: rdata[CTRL_MINUTE_BIT:CTRL_ROUTE_BIT] = ctrl_q;
      SEL_CNT:  rdata = count;
      SEL_STAT: begin
        rdata[STAT_KBD_BIT]   = st_kbd_q;
        rdata[STAT_MOUSE_BIT] = st_mouse_q;
        rdata[STAT_FLAG_BIT]  = flag_q;
      end
    endcase
  end

  assign act         = act_q;
  assign minute_unit = ctrl_q[2];
  assign kbd_en      = ctrl_q[1] | st_kbd_q;
  assign mouse_en    = st_mouse_q;
  assign route_kbrst = ctrl_q[0];
  assign cnt_load    = wr && sel == SEL_CNT;

  // R4: an expiry always leaves the flag set
  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_q);
  // R8: a clearing write without a same-cycle expiry drops the flag
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_STAT && !wdata[STAT_FLAG_BIT] && !expire) |=> !flag_q);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          tick,
  input  logic          evt,
  output logic [DW-1:0] count,
  output logic          expire
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] cnt_q, rel_q;
  logic          armed, reload, dec;

  assign armed  = cnt_q != '0;
  assign reload = armed && evt && !load;
  assign dec    = armed && tick && !load && !reload;
  assign expire = dec && cnt_q == ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
      rel_q <= load_val;
    end else if (reload) begin
      cnt_q <= rel_q;
    end else if (dec) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign count = cnt_q;

  // R2: a load takes the written value
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));
  // R2: a stopped count stays stopped without a load
  p_hold_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !load) |=> count == '0);
  // R3: a plain tick lowers a running count by one
  p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !evt && count != '0) |=> count == $past(count) - ONE);
  // R4: expiry leaves zero behind
  p_zero_after_expire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> count == '0);
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int PW = $clog2(LEN + 1);
  localparam logic [PW-1:0] LEN_V = PW'(LEN);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (fire)           left_q <= LEN_V;
    else if (left_q != '0)   left_q <= left_q - PW'(1);
  end

  assign active = left_q != '0;

  // R5: a fire always starts the pulse on the next cycle
  p_pulse_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> active);
  // R5: the remaining length never exceeds the fixed length
  always_ff @(posedge clk)
    if (rst_n) p_pulse_bound_r5: assert (left_q <= LEN_V);
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
  parameter int DW        = 8,
  parameter int PULSE_LEN = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          sec_tick,
  input  logic          min_tick,
  input  logic          kbd_evt,
  input  logic          mouse_evt,
  output logic          wdt_out_n,
  output logic          kbrst_n
);
  logic [DW-1:0] count;
  logic act, minute_unit, kbd_en, mouse_en, route_kbrst, cnt_load;
  logic expire, pulse_on, tick_sel, evt_any;

  assign tick_sel = minute_unit ? min_tick : sec_tick;
  assign evt_any  = (kbd_evt && kbd_en) || (mouse_evt && mouse_en);

  wdt_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .count(count), .expire(expire), .rdata(reg_rdata), .act(act),
    .minute_unit(minute_unit), .kbd_en(kbd_en), .mouse_en(mouse_en),
    .route_kbrst(route_kbrst), .cnt_load(cnt_load)
  );

  wdt_counter #(.DW(DW)) u_counter (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(reg_wdata),
    .tick(tick_sel), .evt(evt_any), .count(count), .expire(expire)
  );

  wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(expire), .active(pulse_on)
  );

  assign wdt_out_n = !(pulse_on && act);
  assign kbrst_n   = !(pulse_on && act && route_kbrst);

  // R6: the keyboard-reset pulse is never seen without the main pulse
  p_kbrst_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !kbrst_n |-> !wdt_out_n);
  // R5: the outputs stay high when the block is not activated
  p_inactive_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> (wdt_out_n && kbrst_n));
endmodule

// File: tb/test_tick_watchdog.sv
module test_tick_watchdog;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       sec_tick = 1'b0, min_tick = 1'b0, kbd_evt = 1'b0, mouse_evt = 1'b0;
  logic       wdt_out_n, kbrst_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] m_cnt = 0, m_rel = 0;
  logic       m_act = 0, m_flag = 0, m_st7 = 0, m_st6 = 0;
  logic [2:0] m_ctrl = 0;
  int         m_pulse = 0;

  always #10 clk = ~clk;

  tick_watchdog i_tick_watchdog (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
    .min_tick(min_tick), .kbd_evt(kbd_evt), .mouse_evt(mouse_evt),
    .wdt_out_n(wdt_out_n), .kbrst_n(kbrst_n)
  );

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return {7'd0, m_act};
      2'd1:    return {4'd0, m_ctrl, 1'b0};
      2'd2:    return m_cnt;
      default: return {m_st7, m_st6, 1'b0, m_flag, 4'd0};
    endcase
  endfunction

  function automatic logic exp_wdt_n();
    return !(m_pulse != 0 && m_act);
  endfunction

  function automatic logic exp_kbrst_n();
    return !(m_pulse != 0 && m_act && m_ctrl[0]);
  endfunction

  task automatic model_step(input logic w, input logic [1:0] a, input logic [7:0] d,
                            input logic s, input logic m, input logic k, input logic ms);
    logic tk, ev, ld, ex;
    tk = m_ctrl[2] ? m : s;
    ev = (m_cnt != 0) && ((k && (m_ctrl[1] || m_st7)) || (ms && m_st6));
    ld = w && a == 2'd2;
    ex = !ld && !ev && tk && m_cnt == 8'd1;
    m_pulse = ex ? 16 : (m_pulse != 0 ? m_pulse - 1 : 0);
    if (ex) m_flag = 1'b1;
    else if (w && a == 2'd3 && !d[4]) m_flag = 1'b0;
    if (ld) begin m_cnt = d; m_rel = d; end
    else if (ev) m_cnt = m_rel;
    else if (tk && m_cnt != 0) m_cnt = m_cnt - 8'd1;
    if (w && a == 2'd0) m_act = d[0];
    if (w && a == 2'd1) m_ctrl = d[3:1];
    if (w && a == 2'd3) begin m_st7 = d[7]; m_st6 = d[6]; end
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] want,
                       input string what);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, got, want, $time);
    end
  endtask

  task automatic cyc(input string tag, input logic w, input logic [1:0] a,
                     input logic [7:0] d, input logic s = 0, input logic m = 0,
                     input logic k = 0, input logic ms = 0);
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d;
    sec_tick = s; min_tick = m; kbd_evt = k; mouse_evt = ms;
    #1;
    check(tag, reg_rdata, exp_read(a), "rdata");
    check(tag, {7'd0, wdt_out_n}, {7'd0, exp_wdt_n()}, "wdt_out_n");
    check(tag, {7'd0, kbrst_n}, {7'd0, exp_kbrst_n()}, "kbrst_n");
    @(posedge clk);
    model_step(w, a, d, s, m, k, ms);
  endtask

  task automatic idle(input string tag, input int n, input logic [1:0] a);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, a, 8'd0);
  endtask

  function automatic string tag_of(input logic [1:0] a);
    case (a)
      2'd0: return "R5";
      2'd1: return "R6";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h1f2e3d);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) cyc("R1", 1'b0, 2'(a), 8'd0);
    // activate, route, seconds unit, reserved bits written as ones (R9)
    cyc("R9", 1'b1, 2'd0, 8'hFF);
    cyc("R9", 1'b0, 2'd0, 8'd0);
    cyc("R6", 1'b1, 2'd1, 8'hF3);
    cyc("R9", 1'b0, 2'd1, 8'd0);
    cyc("R2", 1'b1, 2'd2, 8'd3);
    cyc("R2", 1'b0, 2'd2, 8'd0);
    cyc("R3", 1'b0, 2'd2, 8'd0, 0, 1);  // minute tick ignored in seconds unit
    for (int i = 0; i < 3; i++) cyc("R3", 1'b0, 2'd2, 8'd0, 1);
    idle("R5", 20, 2'd2);                // pulse of 16 and count held at 0 (R4)
    cyc("R4", 1'b0, 2'd3, 8'd0);
    cyc("R8", 1'b1, 2'd3, 8'h10);        // writing 1 keeps flag
    cyc("R8", 1'b1, 2'd3, 8'h00);        // writing 0 clears flag
    cyc("R8", 1'b0, 2'd3, 8'd0);
    // minute unit, no routing
    cyc("R3", 1'b1, 2'd1, 8'h08);
    cyc("R3", 1'b1, 2'd2, 8'd2);
    cyc("R3", 1'b0, 2'd2, 8'd0, 1);      // second tick ignored
    cyc("R3", 1'b0, 2'd2, 8'd0, 0, 1);
    cyc("R3", 1'b0, 2'd2, 8'd0, 0, 1);
    idle("R6", 18, 2'd1);
    // R2 stop with zero
    cyc("R2", 1'b1, 2'd1, 8'h00);
    cyc("R2", 1'b1, 2'd2, 8'd0);
    for (int i = 0; i < 3; i++) cyc("R2", 1'b0, 2'd2, 8'd0, 1, 1, 1, 1);
    // R7 events
    cyc("R7", 1'b1, 2'd3, 8'h40);
    cyc("R7", 1'b1, 2'd2, 8'd4);
    cyc("R7", 1'b0, 2'd2, 8'd0, 1);
    cyc("R7", 1'b0, 2'd2, 8'd0, 0, 0, 0, 1);
    cyc("R7", 1'b0, 2'd2, 8'd0, 1);
    cyc("R7", 1'b0, 2'd2, 8'd0, 0, 0, 1, 0);  // keyboard disabled
    cyc("R7", 1'b1, 2'd1, 8'h04);
    cyc("R7", 1'b0, 2'd2, 8'd0, 0, 0, 1, 0);  // keyboard enabled by control
    // R9 priority
    cyc("R9", 1'b1, 2'd2, 8'd7, 1, 0, 1, 1);
    cyc("R9", 1'b0, 2'd2, 8'd0, 1, 0, 0, 1);
    cyc("R9", 1'b0, 2'd2, 8'd0);
    // R8 expiry colliding with a clearing write; R5 re-expiry during a pulse
    cyc("R8", 1'b1, 2'd2, 8'd1);
    cyc("R8", 1'b1, 2'd3, 8'h00, 1);
    cyc("R8", 1'b0, 2'd3, 8'd0);
    cyc("R5", 1'b1, 2'd2, 8'd1);
    idle("R5", 4, 2'd0);
    cyc("R5", 1'b0, 2'd0, 8'd0, 1);
    idle("R5", 20, 2'd0);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic w; logic [1:0] a; logic [7:0] d;
      w = ($urandom % 12) == 0;
      a = 2'($urandom % 4);
      d = (a == 2'd2) ? 8'($urandom % 6) : 8'($urandom);
      cyc(tag_of(a), w, a, d, ($urandom % 3) == 0, ($urandom % 3) == 0,
          ($urandom % 10) == 0, ($urandom % 10) == 0);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule